// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block turns the input levels of a small GPIO port into interrupt status. Each pin has its own trigger setup. A pin can watch for a level or for a change. A change can be a chosen edge or either edge. A polarity bit picks which level or which edge counts as active. Hits are caught in a sticky raw status register. Software clears that register by writing ones to a clear port. A per-pin mask then selects which status bits drive the single combined interrupt line.

The register values come in on ports from a bus decoder that sits outside this block. Input synchronizers also sit upstream. Edges are found by comparing each pin with a copy of its level registered on the previous clock. The status register updates on the same clock edge that samples the change, so a new hit appears on `raw_o` one cycle after the pin moves.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset is released, with all pins low and no configuration set, `raw_o`, `masked_o` and `irq_o` are all zero.
- R2: Bit n of `sense_i` picks the detection kind for pin n: 1 means level detection, 0 means edge detection.
- R3: A pin in edge mode with its `both_i` bit at 1 sets its status bit on a rising change and also on a falling change.
- R4: A pin in edge mode with its `both_i` bit at 0 sets status only when the new level equals its `event_i` bit. So `event_i`=1 catches rising changes and `event_i`=0 catches falling changes. A change in the other direction sets nothing.
- R5: A pin in level mode sets its status bit on every clock where its level equals its `event_i` bit. If a clear hits that bit while the level is still active, the bit stays set.
- R6: A pin whose `dir_i` bit is 1 (output) never causes an edge hit, whichever way it toggles.
- R7: `masked_o` equals `raw_o` AND `mask_i`. `irq_o` is 1 exactly when `masked_o` is nonzero.
- R8: On a clock where `clr_we_i` is 1, every status bit at a position where `clr_data_i` is 1 is cleared. The other bits keep their value.
- R9: If a hit and a clear reach the same status bit on the same clock, the bit ends up set.
- R10: An edge is a difference from the level sampled on the previous clock. A pin held steady in edge mode does not set its bit again after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Synchronized pin levels |
| dir_i | input | NUM_PINS | Direction per pin, 1 = output |
| sense_i | input | NUM_PINS | 1 = level detection, 0 = edge detection |
| both_i | input | NUM_PINS | 1 = either edge triggers (edge mode) |
| event_i | input | NUM_PINS | Active level, or active edge direction |
| mask_i | input | NUM_PINS | Interrupt enable per pin |
| clr_we_i | input | 1 | Clear strobe |
| clr_data_i | input | NUM_PINS | Write-one-to-clear bit pattern |
| raw_o | output | NUM_PINS | Sticky raw status |
| masked_o | output | NUM_PINS | Raw status AND mask |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a hit and a clear landing on the same status bit in one clock. The stimulus first leaves a bit set. It then moves that pin on the same cycle that it writes a one to the same bit position, so the set-wins rule is tested in both edge and level mode. Held levels come next: a level-mode pin is cleared while it is still active and must set again, and an edge-mode pin that is cleared while held must stay clear. These two cases tell apart the two ways status can be raised again.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic {
    SENSE_EDGE  = 1'b0,
    SENSE_LEVEL = 1'b1
  } sense_e;

  // pin sits at the polarity selected by the event bit
  function automatic logic at_polarity(input logic lvl, input logic pol);
    return ~(lvl ^ pol);
  endfunction

endpackage

// File: rtl/gpio_irq_edge_det.sv
module gpio_irq_edge_det
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] sense_i,
  input  logic [NUM_PINS-1:0] both_i,
  input  logic [NUM_PINS-1:0] event_i,
  output logic [NUM_PINS-1:0] edge_o
);

  logic [NUM_PINS-1:0] prev_q;
  logic                armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= pin_i;
      armed_q <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    logic moved;
    always_comb begin
      moved     = (pin_i[g] ^ prev_q[g]) & ~dir_i[g];
      edge_o[g] = moved && (sense_i[g] == SENSE_EDGE) &&
                  (both_i[g] || at_polarity(pin_i[g], event_i[g]));
    end
  end

  // a steady pin never produces an edge hit
  p_no_edge_steady_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && (pin_i == $past(pin_i))) |-> (edge_o == '0))
    else $error("edge hit without pin change");

  // any change on an input pin in both-edge mode gives a hit
  p_both_edges_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (((~dir_i & ~sense_i & both_i & (pin_i ^ $past(pin_i))) & ~edge_o) == '0))
    else $error("both-edge change missed");

  // output pins never give edge hits
  p_dir_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> ((edge_o & dir_i) == '0))
    else $error("edge hit on output pin");

endmodule

// File: rtl/gpio_irq_level_det.sv
module gpio_irq_level_det
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] sense_i,
  input  logic [NUM_PINS-1:0] event_i,
  output logic [NUM_PINS-1:0] level_o
);

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    assign level_o[g] = (sense_i[g] == SENSE_LEVEL) && at_polarity(pin_i[g], event_i[g]);
  end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] set_i,
  input  logic                clr_we_i,
  input  logic [NUM_PINS-1:0] clr_data_i,
  output logic [NUM_PINS-1:0] raw_o
);

  logic [NUM_PINS-1:0] raw_q;
  logic [NUM_PINS-1:0] clr_mask;

  assign clr_mask = clr_we_i ? clr_data_i : '0;

  // set is applied after clear so a coincident event survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= '0;
    else         raw_q <= (raw_q & ~clr_mask) | set_i;
  end

  assign raw_o = raw_q;

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((raw_q & $past(clr_data_i & ~set_i)) == '0))
    else $error("cleared bit still set");

  p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((raw_q & $past(raw_q)) == $past(raw_q)))
    else $error("status bit lost without clear");

  p_set_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((raw_q & $past(set_i)) == $past(set_i)))
    else $error("hit lost");

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] sense_i,
  input  logic [NUM_PINS-1:0] both_i,
  input  logic [NUM_PINS-1:0] event_i,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic                clr_we_i,
  input  logic [NUM_PINS-1:0] clr_data_i,
  output logic [NUM_PINS-1:0] raw_o,
  output logic [NUM_PINS-1:0] masked_o,
  output logic                irq_o
);

  logic [NUM_PINS-1:0] edge_hit;
  logic [NUM_PINS-1:0] level_hit;
  logic [NUM_PINS-1:0] set_vec;

  gpio_irq_edge_det #(.NUM_PINS(NUM_PINS)) u_edge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (pin_i),
    .dir_i   (dir_i),
    .sense_i (sense_i),
    .both_i  (both_i),
    .event_i (event_i),
    .edge_o  (edge_hit)
  );

  gpio_irq_level_det #(.NUM_PINS(NUM_PINS)) u_level (
    .pin_i   (pin_i),
    .sense_i (sense_i),
    .event_i (event_i),
    .level_o (level_hit)
  );

  assign set_vec = edge_hit | level_hit;

  gpio_irq_status #(.NUM_PINS(NUM_PINS)) u_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (set_vec),
    .clr_we_i   (clr_we_i),
    .clr_data_i (clr_data_i),
    .raw_o      (raw_o)
  );

  assign masked_o = raw_o & mask_i;
  assign irq_o    = |masked_o;

  // an active level always shows in status on the next cycle, clear or not
  p_level_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((sense_i & ~(pin_i ^ event_i)) != '0) |=>
      ((raw_o & $past(sense_i & ~(pin_i ^ event_i))) == $past(sense_i & ~(pin_i ^ event_i))))
    else $error("active level not in status");

  p_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((raw_o & mask_i) != '0))
    else $error("irq without masked status");

endmodule

// File: tb/gpio_irq_detect_test.sv
`timescale 1ns/100ps
module gpio_irq_detect_test;

  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] pin_i = '0, dir_i = '0, sense_i = '0, both_i = '0, event_i = '0, mask_i = '0;
  logic         clr_we_i = 1'b0;
  logic [N-1:0] clr_data_i = '0;
  logic [N-1:0] raw_o, masked_o;
  logic         irq_o;

  always #2 clk = ~clk;

  gpio_irq_detect #(.NUM_PINS(N)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pin_i), .dir_i(dir_i), .sense_i(sense_i),
    .both_i(both_i), .event_i(event_i), .mask_i(mask_i), .clr_we_i(clr_we_i),
    .clr_data_i(clr_data_i), .raw_o(raw_o), .masked_o(masked_o), .irq_o(irq_o)
  );

  typedef struct {
    logic [N-1:0] raw;
    logic [N-1:0] msk;
    logic         irq;
    string        tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  // next configuration, applied by step()
  logic [N-1:0] n_dir = '0, n_sense = '0, n_both = '0, n_evt = '0, n_mask = 8'hFF;
  logic [N-1:0] m_prev = '0, m_raw = '0;

  task automatic step(input logic [N-1:0] pin, input logic we, input logic [N-1:0] clr,
                      input string tag);
    logic [N-1:0] moved, hit, set;
    exp_t e;
    @(negedge clk);
    dir_i = n_dir; sense_i = n_sense; both_i = n_both; event_i = n_evt; mask_i = n_mask;
    pin_i = pin; clr_we_i = we; clr_data_i = clr;
    moved = (pin ^ m_prev) & ~n_dir;
    hit   = ~(pin ^ n_evt);
    set   = (moved & ~n_sense & (n_both | hit)) | (n_sense & hit);
    m_raw = (m_raw & ~(we ? clr : '0)) | set;
    m_prev = pin;
    @(posedge clk);
    #0.5;
    e.raw = m_raw; e.msk = m_raw & n_mask; e.irq = |(m_raw & n_mask); e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (raw_o !== e.raw || masked_o !== e.msk || irq_o !== e.irq) begin
          errors++;
          $display("FAIL %s: raw=%h masked=%h irq=%b, expected raw=%h masked=%h irq=%b",
                   e.tag, raw_o, masked_o, irq_o, e.raw, e.msk, e.irq);
        end
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    // R1 reset state
    checks++;
    if (raw_o !== '0 || masked_o !== '0 || irq_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: raw=%h masked=%h irq=%b, expected 00 00 0", raw_o, masked_o, irq_o);
    end
    step(8'h00, 0, 8'h00, "R1 idle after reset");

    // R3 any edge on pin0
    n_both = 8'h01;
    step(8'h01, 0, 8'h00, "R3 rising with both-edges");
    step(8'h01, 1, 8'h01, "R8 clear pin0");
    step(8'h00, 0, 8'h00, "R3 falling with both-edges");
    step(8'h00, 1, 8'hFF, "R8 clear all");

    // R4 single edge: pin1 rising, pin2 falling
    n_both = 8'h00; n_evt = 8'h02;
    step(8'h04, 0, 8'h00, "R4 rising on falling-select pin ignored");
    step(8'h06, 0, 8'h00, "R4 rising on rising-select pin");
    step(8'h02, 1, 8'h02, "R4 falling on falling-select pin");
    step(8'h00, 1, 8'h04, "R4 falling on rising-select pin ignored");

    // R6 output pin
    n_dir = 8'h08; n_both = 8'h08;
    step(8'h08, 0, 8'h00, "R6 output pin rise ignored");
    step(8'h00, 0, 8'h00, "R6 output pin fall ignored");
    n_dir = 8'h00;

    // R5 / R2 level on pin4, active high
    n_sense = 8'h10; n_evt = 8'h10;
    step(8'h00, 0, 8'h00, "R5 inactive level");
    step(8'h10, 0, 8'h00, "R5 active level sets");
    step(8'h10, 1, 8'h10, "R5 re-asserts after clear");
    step(8'h10, 0, 8'h00, "R2 level mode holds");
    step(8'h00, 1, 8'h10, "R5 inactive then clear");
    n_sense = 8'h00;

    // R10 held edge pin
    n_both = 8'h20;
    step(8'h20, 0, 8'h00, "R10 edge on pin5");
    step(8'h20, 1, 8'h20, "R10 clear while held");
    step(8'h20, 0, 8'h00, "R10 no re-set while held");

    // R9 set and clear same bit
    step(8'h00, 1, 8'h20, "R9 set wins over clear");

    // R7 mask
    n_mask = 8'h00;
    step(8'h00, 0, 8'h00, "R7 all masked");
    n_mask = 8'h20;
    step(8'h00, 0, 8'h00, "R7 unmasked bit");
    n_mask = 8'hDF;
    step(8'h00, 0, 8'h00, "R7 other bits unmasked");

    // R8 partial clear
    n_both = 8'hFF; n_mask = 8'hFF;
    step(8'h0F, 0, 8'h00, "R8 set several");
    step(8'h0F, 1, 8'h05, "R8 partial clear");

    // R9 level pin with clear
    n_sense = 8'h80; n_evt = 8'h00;
    step(8'h0F, 1, 8'hFF, "R9 level hit beats clear");

    repeat (3) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule